// File: doc/BRIEF.md
# Prioritized Interrupt Router with Fast and Normal Lines

This block gathers thirteen peripheral interrupt requests and turns them into two CPU interrupt lines. One is a fast line that the CPU cannot mask; the other is a normal, maskable line. Each request input has its own fixed detection type, set by a parameter vector: either edge, rising edge only, active-low level, active-high level, or a single-clock low pulse. Edge-type requests leave a sticky pending flag that software clears through an acknowledge register. Level-type requests show the live synchronized input.

Software programs an enable mask, a per-source route bit (fast or normal line), and a per-source priority value through a simple register port. For each line the block reports whether any enabled request routed to it is active, and gives the number of the winning source. While the CPU sleeps, any enabled active request raises a wake-up output. After reset only the power-fail source is enabled, and it is routed to the fast line.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the enable register (address 0) reads 0x0008, the route register (address 1) reads 0x0008, the pending register (address 2) reads 0, every priority register (address 4+i) reads 0, and fiq_o, irq_o and wake_o are low.
- R2: Sources 0, 1, 6, 7, 8, 9 and 12 set their pending bit (bit i of address 2) on both a rising and a falling input change, and the bit stays set until acknowledged.
- R3: Source 2 sets its pending bit on a rising input change only; a falling change leaves it clear.
- R4: Source 3 (power fail) is active-low level: its pending bit is the inverse of the synchronized input and clears without acknowledge when the input returns high.
- R5: Sources 4, 10 and 11 are active-high level: their pending bits follow the synchronized input.
- R6: Source 5 captures an input that is low for exactly one clock, and keeps the pending bit set until acknowledged.
- R7: Writing address 3 clears the pending bit of each edge-type source whose data bit is 1; level-type sources are not affected.
- R8: A source whose bit in the enable register is 0 still shows in the pending register but drives neither fiq_o nor irq_o.
- R9: An enabled pending source with route bit 1 drives fiq_o; with route bit 0 it drives irq_o.
- R10: fiq_id_o and irq_id_o give the source number with the largest priority value (4-bit field at address 4+i) among the active requests on that line; on equal priority the lower source number wins; with no request the id is 0.
- R11: wake_o is high exactly while sleep_i is high and at least one enabled source is pending.
- R12: An input change shows in a level-type pending bit after the second rising clock edge, and in an edge-type pending bit after the third, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 13 | Raw interrupt request inputs, one per source |
| sleep_i | input | 1 | CPU is in sleep mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| fiq_o | output | 1 | Fast interrupt request |
| fiq_id_o | output | 4 | Winning source number on the fast line |
| irq_o | output | 1 | Normal interrupt request |
| irq_id_o | output | 4 | Winning source number on the normal line |
| wake_o | output | 1 | Wake-up request |

## Verification
The arbitration is driven from a table of level-input combinations on the four level sources, which separates a single winner, a strictly higher priority, an equal-priority tie resolved by source number, and simultaneous activity on both lines. Directed sequences then toggle edge sources up and down to tell either-edge from rising-only detection, issue a one-clock low pulse to prove capture, and acknowledge level sources to show the acknowledge has no hold on them. Masking, rerouting and sleep are each flipped around a pending request so that the pending register and the line outputs disagree in exactly the way each requirement predicts.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      DET_ANY       = 3'd0,
      DET_RISE      = 3'd1,
      DET_LOW_LVL   = 3'd2,
      DET_HIGH_LVL  = 3'd3,
      DET_LOW_PULSE = 3'd4
   } det_mode_e;

   localparam int DEF_NSRC = 13;

   // Source 12 first (MSB), source 0 last.
   localparam logic [3*DEF_NSRC-1:0] DEF_MODES = {
      DET_ANY, DET_HIGH_LVL, DET_HIGH_LVL, DET_ANY, DET_ANY, DET_ANY, DET_ANY,
      DET_LOW_PULSE, DET_HIGH_LVL, DET_LOW_LVL, DET_RISE, DET_ANY, DET_ANY};

   localparam int ADDR_MASK  = 0;
   localparam int ADDR_ROUTE = 1;
   localparam int ADDR_PEND  = 2;
   localparam int ADDR_ACK   = 3;
   localparam int ADDR_PRIO0 = 4;
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
   parameter irq_pkg::det_mode_e MODE = irq_pkg::DET_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic clr_i,
   output logic pend_o
);
   import irq_pkg::*;

   localparam logic IDLE = (MODE == DET_LOW_LVL) || (MODE == DET_LOW_PULSE);
   localparam bit   IS_LEVEL = (MODE == DET_LOW_LVL) || (MODE == DET_HIGH_LVL);

   logic s1_q, s2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= IDLE;
         s2_q <= IDLE;
      end else begin
         s1_q <= src_i;
         s2_q <= s1_q;
      end
   end

   if (MODE > DET_LOW_PULSE) begin : g_bad_mode
      $error("irq_src_detect: unknown detection mode");
   end

   if (IS_LEVEL) begin : g_level
      logic unused_clr;
      assign unused_clr = clr_i;
      assign pend_o = (MODE == DET_LOW_LVL) ? ~s2_q : s2_q;
   end else begin : g_edge
      logic prev_q, pend_q, evt;

      always_comb begin
         case (MODE)
            DET_RISE:      evt = s2_q & ~prev_q;
            DET_LOW_PULSE: evt = ~s2_q & prev_q;
            default:       evt = s2_q ^ prev_q;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= IDLE;
            pend_q <= 1'b0;
         end else begin
            prev_q <= s2_q;
            if (evt)        pend_q <= 1'b1;
            else if (clr_i) pend_q <= 1'b0;
         end
      end

      assign pend_o = pend_q;

      // R2/R6: sticky until acknowledged
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q && !clr_i) |=> pend_q);
      // R2: a pending bit only rises after a detected event
      a_r2_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_q) |-> $past(evt));
      // R7: acknowledge without a new event clears
      a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !evt) |=> !pend_q);
   end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
   parameter int N  = 13,
   parameter int PW = 4,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]    req_i,
   input  logic [N*PW-1:0] prio_i,
   output logic            valid_o,
   output logic [IW-1:0]   id_o
);
   logic [PW-1:0] best;

   if (N < 2) begin : g_bad_n
      $error("irq_prio_select: N must be at least 2");
   end

   // Strict compare while walking upward keeps the lower number on ties.
   always_comb begin
      valid_o = 1'b0;
      id_o    = '0;
      best    = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && (!valid_o || prio_i[i*PW +: PW] > best)) begin
            valid_o = 1'b1;
            id_o    = IW'(i);
            best    = prio_i[i*PW +: PW];
         end
      end
   end

   // R10: the reported winner is an active request
   always_comb begin
      if (valid_o) a_r10_id_requesting: assert (req_i[id_o]);
   end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
   parameter int NSRC = irq_pkg::DEF_NSRC,
   parameter int PW   = 4,
   parameter int DW   = 16,
   parameter int AW   = 5,
   parameter int FAIL_SRC = 3,
   parameter logic [3*NSRC-1:0] SRC_MODE = irq_pkg::DEF_MODES,
   localparam int IW = $clog2(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic            sleep_i,
   input  logic            reg_we,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            fiq_o,
   output logic [IW-1:0]   fiq_id_o,
   output logic            irq_o,
   output logic [IW-1:0]   irq_id_o,
   output logic            wake_o
);
   import irq_pkg::*;

   localparam logic [NSRC-1:0] RST_BIT = NSRC'(1) << FAIL_SRC;

   if (NSRC > DW) begin : g_bad_width
      $error("irq_route_ctrl: NSRC must fit in one data word");
   end
   if (ADDR_PRIO0 + NSRC > (1 << AW)) begin : g_bad_addr
      $error("irq_route_ctrl: address space too small");
   end
   if (PW > DW || FAIL_SRC >= NSRC) begin : g_bad_misc
      $error("irq_route_ctrl: bad PW or FAIL_SRC");
   end

   logic [NSRC-1:0]    mask_q, route_q, pend, eff, clr;
   logic [NSRC*PW-1:0] prio_q;
   logic               unused_wbits;

   assign unused_wbits = ^reg_wdata;
   assign clr = (reg_we && reg_addr == AW'(ADDR_ACK)) ? reg_wdata[NSRC-1:0] : '0;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      irq_src_detect #(.MODE(det_mode_e'(SRC_MODE[3*i +: 3]))) u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src_i[i]),
         .clr_i  (clr[i]),
         .pend_o (pend[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= RST_BIT;
         route_q <= RST_BIT;
         prio_q  <= '0;
      end else if (reg_we) begin
         if (reg_addr == AW'(ADDR_MASK))  mask_q  <= reg_wdata[NSRC-1:0];
         if (reg_addr == AW'(ADDR_ROUTE)) route_q <= reg_wdata[NSRC-1:0];
         for (int i = 0; i < NSRC; i++)
            if (reg_addr == AW'(ADDR_PRIO0 + i)) prio_q[i*PW +: PW] <= reg_wdata[PW-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == AW'(ADDR_MASK))  reg_rdata = DW'(mask_q);
      if (reg_addr == AW'(ADDR_ROUTE)) reg_rdata = DW'(route_q);
      if (reg_addr == AW'(ADDR_PEND))  reg_rdata = DW'(pend);
      for (int i = 0; i < NSRC; i++)
         if (reg_addr == AW'(ADDR_PRIO0 + i)) reg_rdata = DW'(prio_q[i*PW +: PW]);
   end

   assign eff = pend & mask_q;

   irq_prio_select #(.N(NSRC), .PW(PW)) u_sel_fast (
      .req_i (eff & route_q), .prio_i (prio_q), .valid_o (fiq_o), .id_o (fiq_id_o));

   irq_prio_select #(.N(NSRC), .PW(PW)) u_sel_norm (
      .req_i (eff & ~route_q), .prio_i (prio_q), .valid_o (irq_o), .id_o (irq_id_o));

   assign wake_o = sleep_i & (fiq_o | irq_o);

   // R8: only enabled sources reach a line
   a_r8_fast_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> mask_q[fiq_id_o]);
   // R9: each line carries only sources routed to it
   a_r9_fast_route: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> route_q[fiq_id_o]);
   a_r9_norm_route: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !route_q[irq_id_o]);
   // R11: sleeping with an enabled pending source requests wake-up
   a_r11_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && |(pend & mask_q)) |-> wake_o);
endmodule

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] src;
   logic        sleep_i = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = 5'd2;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        fiq_o, irq_o, wake_o;
   logic [3:0]  fiq_id_o, irq_id_o;
   int          n_run = 0, n_fail = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   irq_route_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .sleep_i(sleep_i),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fiq_o(fiq_o), .fiq_id_o(fiq_id_o), .irq_o(irq_o), .irq_id_o(irq_id_o), .wake_o(wake_o));

   // {in s11,s10,s4,s3 , fiq, fiq_id, irq, irq_id}
   localparam logic [13:0] VEC [8] = '{
      14'b0001_0_0000_0_0000,
      14'b0000_1_0011_0_0000,
      14'b0011_0_0000_1_0100,
      14'b0111_0_0000_1_0100,
      14'b0101_0_0000_1_1010,
      14'b1111_0_0000_1_1011,
      14'b1100_1_0011_1_1011,
      14'b1001_0_0000_1_1011};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 5'd2;
      #1;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      reg_addr = a; #1; d = reg_rdata; reg_addr = 5'd2; #1;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      src = 13'b0_0000_0010_1000;   // src3 and src5 idle high
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);

      // R1 reset state
      rd(5'd0, d);  chk("R1 mask", d, 16'h0008);
      rd(5'd1, d);  chk("R1 route", d, 16'h0008);
      rd(5'd2, d);  chk("R1 pending", d, 16'h0000);
      rd(5'd4, d);  chk("R1 prio0", d, 0);
      rd(5'd16, d); chk("R1 prio12", d, 0);
      chk("R1 lines", {fiq_o, irq_o, wake_o}, 0);

      wr(5'd0, 16'h1FFF);
      wr(5'd7, 16'd2);    // src3
      wr(5'd8, 16'd5);    // src4
      wr(5'd14, 16'd5);   // src10
      wr(5'd15, 16'd7);   // src11
      wr(5'd4, 16'd1);    // src0
      rd(5'd15, d); chk("R10 prio write", d, 7);

      // table: level sources, arbitration and routing
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         {src[11], src[10], src[4], src[3]} = VEC[k][13:10];
         wait_n(3);
         chk($sformatf("R4 R5 R9 R10 vec%0d fiq", k), fiq_o, VEC[k][9]);
         chk($sformatf("R4 R5 R9 R10 vec%0d fiq_id", k), fiq_id_o, VEC[k][8:5]);
         chk($sformatf("R4 R5 R9 R10 vec%0d irq", k), irq_o, VEC[k][4]);
         chk($sformatf("R4 R5 R9 R10 vec%0d irq_id", k), irq_id_o, VEC[k][3:0]);
      end
      @(negedge clk);
      {src[11], src[10], src[4], src[3]} = 4'b0001;
      wait_n(3);
      chk("R4 release", {fiq_o, irq_o}, 0);

      // R12 latency and R2 rising
      @(negedge clk); src[0] = 1'b1;
      wait_n(2);
      chk("R12 edge not yet", reg_rdata[0], 0);
      wait_n(1);
      chk("R12 R2 edge set", reg_rdata[0], 1);
      chk("R2 irq id", {irq_o, irq_id_o}, {1'b1, 4'd0});
      wait_n(3);
      chk("R2 sticky", reg_rdata[0], 1);
      wr(5'd3, 16'h0001);
      chk("R7 ack", reg_rdata[0], 0);
      @(negedge clk); src[0] = 1'b0;
      wait_n(4);
      chk("R2 falling", reg_rdata[0], 1);
      wr(5'd3, 16'h0001);

      // R3 rising only
      @(negedge clk); src[2] = 1'b1;
      wait_n(4);
      chk("R3 rise", reg_rdata[2], 1);
      wr(5'd3, 16'h0004);
      @(negedge clk); src[2] = 1'b0;
      wait_n(4);
      chk("R3 fall ignored", reg_rdata[2], 0);

      // R6 one-clock low pulse
      @(negedge clk); src[5] = 1'b0;
      @(negedge clk); src[5] = 1'b1;
      wait_n(4);
      chk("R6 pulse captured", reg_rdata[5], 1);
      wait_n(3);
      chk("R6 sticky", reg_rdata[5], 1);
      wr(5'd3, 16'h0020);
      chk("R6 ack", reg_rdata[5], 0);

      // R7 acknowledge has no effect on a level source; R12 level latency
      @(negedge clk); src[4] = 1'b1;
      wait_n(1);
      chk("R12 level not yet", reg_rdata[4], 0);
      wait_n(1);
      chk("R12 level set", reg_rdata[4], 1);
      wr(5'd3, 16'h0010);
      chk("R7 level ignored", reg_rdata[4], 1);
      chk("R7 level line", {irq_o, irq_id_o}, {1'b1, 4'd4});
      @(negedge clk); src[4] = 1'b0;
      wait_n(3);

      // R8 mask
      wr(5'd0, 16'h0FFF);
      @(negedge clk); src[12] = 1'b1;
      wait_n(4);
      chk("R8 masked pending", reg_rdata[12], 1);
      chk("R8 masked line", irq_o, 0);
      wr(5'd0, 16'h1FFF);
      chk("R8 unmasked", {irq_o, irq_id_o}, {1'b1, 4'd12});
      wr(5'd3, 16'h1000);
      chk("R8 cleared", irq_o, 0);

      // R9 route to fast line
      wr(5'd1, 16'h0009);
      @(negedge clk); src[0] = 1'b1;
      wait_n(4);
      chk("R9 fast", {fiq_o, fiq_id_o}, {1'b1, 4'd0});
      chk("R9 not normal", irq_o, 0);
      wr(5'd3, 16'h0001);
      wr(5'd1, 16'h0008);

      // R11 wake-up
      sleep_i = 1'b1; #1;
      chk("R11 idle sleep", wake_o, 0);
      @(negedge clk); src[10] = 1'b1;
      wait_n(3);
      chk("R11 wake", wake_o, 1);
      sleep_i = 1'b0; #1;
      chk("R11 awake", wake_o, 0);
      @(negedge clk); src[10] = 1'b0;
      wait_n(3);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule